// File: doc/BRIEF.md
# Interrupt Mask Register with Atomic Set and Clear Commands

This block keeps a 64-bit mask over 64 interrupt sources and exposes it on a plain synchronous register bus. Software may overwrite either 32-bit half of the mask directly. It may also use two byte-wide command offsets. One command masks a single source, or every source at once. The other unmasks a single source, or every source at once. A one-bit command needs no read-modify-write of the mask, so it cannot race with another agent that updates the mask.

Each cycle the raw pending lines are combined with the mask. The block registers the resulting masked pending vector and a single request line that is the OR of that vector. A write to an offset the block does not decode raises a one-cycle error pulse. Such a write changes nothing.

Top module: `irq_mask_reg`

## Requirements
- R1: After reset all 64 mask bits are 1, so `irq_req` is 0 and `irq_masked` is all zero whatever `irq_pend` holds.
- R2: A write to offset 0x0C replaces mask bits 31:0 with `wdata`. Mask bits 63:32 keep their values.
- R3: A write to offset 0x08 replaces mask bits 63:32 with `wdata`. Mask bits 31:0 keep their values.
- R4: A write to offset 0x1C with bit 6 of `wdata` equal to 1 sets all 64 mask bits.
- R5: A write to offset 0x1C with bit 6 equal to 0 sets the mask bit whose index is `wdata[5:0]`. Every other mask bit keeps its value.
- R6: A write to offset 0x1D with bit 6 of `wdata` equal to 1 clears all 64 mask bits.
- R7: A write to offset 0x1D with bit 6 equal to 0 clears the mask bit whose index is `wdata[5:0]`. Every other mask bit keeps its value.
- R8: `irq_masked` equals `irq_pend & ~mask`, and `irq_req` is its OR. Both are registered. They reflect a mask write one clock after the write and a change on `irq_pend` one clock after the change.
- R9: A read of 0x0C returns mask bits 31:0 and a read of 0x08 returns mask bits 63:32. Reads of 0x1C and 0x1D return zero. `rdata` is combinational on `addr`.
- R10: A write to any other offset pulses `wr_err` high for exactly the next clock cycle and leaves the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq_pend | input | 64 | Raw pending lines |
| irq_masked | output | 64 | Registered pending vector with masked sources removed |
| irq_req | output | 1 | Registered OR of `irq_masked` |
| wr_err | output | 1 | One-cycle pulse after a write to an undecoded offset |

## Verification
A wrong mask bit is visible on two paths. It shows in the readback of its half at once. It also shows on `irq_masked` one clock later if the matching pending line is high, so the bench holds pending lines high while it changes the mask. A command that touches too many bits shows up as a difference in the readback of a neighbouring bit, or of the other half. A missed decode shows as a missing or stray `wr_err` pulse on the cycle after the write, together with a mask readback that has changed.

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int N_SRC  = 64,
  parameter int AW     = 8,
  parameter int DW     = 32,
  parameter logic [AW-1:0] OFS_HI  = 8'h08,
  parameter logic [AW-1:0] OFS_LO  = 8'h0C,
  parameter logic [AW-1:0] OFS_SET = 8'h1C,
  parameter logic [AW-1:0] OFS_CLR = 8'h1D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [N_SRC-1:0] irq_pend,
  output logic [N_SRC-1:0] irq_masked,
  output logic             irq_req,
  output logic             wr_err
);
  localparam int IW      = $clog2(N_SRC);
  localparam int ALL_BIT = IW;

  logic [N_SRC-1:0] mask_q, mask_d, onehot;
  logic hit_hi, hit_lo, hit_set, hit_clr, hit_any;

  assign hit_hi  = addr == OFS_HI;
  assign hit_lo  = addr == OFS_LO;
  assign hit_set = addr == OFS_SET;
  assign hit_clr = addr == OFS_CLR;
  assign hit_any = hit_hi | hit_lo | hit_set | hit_clr;

  assign onehot = {{(N_SRC-1){1'b0}}, 1'b1} << wdata[IW-1:0];

  always_comb begin
    mask_d = mask_q;
    if (wr_en) begin
      if (hit_lo)
        mask_d[DW-1:0] = wdata;
      else if (hit_hi)
        mask_d[N_SRC-1:DW] = wdata;
      else if (hit_set)
        mask_d = wdata[ALL_BIT] ? {N_SRC{1'b1}} : (mask_q | onehot);
      else if (hit_clr)
        mask_d = wdata[ALL_BIT] ? {N_SRC{1'b0}} : (mask_q & ~onehot);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q     <= {N_SRC{1'b1}};
      irq_masked <= '0;
      irq_req    <= 1'b0;
      wr_err     <= 1'b0;
    end else begin
      mask_q     <= mask_d;
      irq_masked <= irq_pend & ~mask_q;
      irq_req    <= |(irq_pend & ~mask_q);
      wr_err     <= wr_en & ~hit_any;
    end
  end

  assign rdata = hit_lo ? mask_q[DW-1:0] :
                 hit_hi ? mask_q[N_SRC-1:DW] : '0;
endmodule

module irq_mask_reg_chk #(
  parameter int N_SRC = 64,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [AW-1:0]    addr,
  input logic [DW-1:0]    wdata,
  input logic [DW-1:0]    rdata,
  input logic [N_SRC-1:0] irq_masked,
  input logic             irq_req,
  input logic             wr_err
);
  logic known;
  always_ff @(posedge clk) known <= rst_n;

  assert_req_or_R8: assert property (@(posedge clk) disable iff (!rst_n || !known)
    irq_req == (|irq_masked));
  assert_err_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n || !known)
    wr_err |=> !wr_err || $past(wr_en));
  assert_bad_write_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != 8'h08 && addr != 8'h0C && addr != 8'h1C && addr != 8'h1D) |=> wr_err);
  assert_cmd_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 8'h1C || addr == 8'h1D) |-> rdata == '0);
  assert_set_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h1C && wdata[6] && addr != 8'h0C) |=> (addr != 8'h0C || rdata == '1));
  assert_clr_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h1D && wdata[6]) |=> (addr != 8'h08 || rdata == '0));
  assert_good_write_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == 8'h08 || addr == 8'h0C)) |=> !wr_err);
endmodule

bind irq_mask_reg irq_mask_reg_chk #(.N_SRC(N_SRC), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .irq_masked(irq_masked), .irq_req(irq_req), .wr_err(wr_err)
);

// File: tb/tb_irq_mask_reg.sv
module tb_irq_mask_reg;
  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [63:0] irq_pend = 0, irq_masked;
  logic        irq_req, wr_err;
  logic [63:0] model;
  int checks = 0, fails = 0;
  bit done = 0;

  irq_mask_reg dut (.*);

  always #4 clk = ~clk;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic logic [63:0] apply(logic [63:0] m, logic [7:0] a, logic [31:0] d);
    logic [63:0] r = m;
    case (a)
      8'h0C: r[31:0] = d;
      8'h08: r[63:32] = d;
      8'h1C: r = d[6] ? '1 : (m | (64'd1 << d[5:0]));
      8'h1D: r = d[6] ? '0 : (m & ~(64'd1 << d[5:0]));
      default: r = m;
    endcase
    return r;
  endfunction

  function automatic bit decoded(logic [7:0] a);
    return a == 8'h08 || a == 8'h0C || a == 8'h1C || a == 8'h1D;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, string req);
    logic [63:0] exp_mask = apply(model, a, d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
    chk({req, " err"}, wr_err, !decoded(a));
    model = exp_mask;
    @(negedge clk);
    chk({req, " err_pulse"}, wr_err, 0);
  endtask

  task automatic read_all(string req);
    @(negedge clk); addr = 8'h0C; #1 chk({req, " lo"}, rdata, model[31:0]);
    addr = 8'h08; #1 chk({req, " hi"}, rdata, model[63:32]);
    @(negedge clk);
    chk({req, " masked"}, irq_masked, irq_pend & ~model);
    chk({req, " req"}, irq_req, |(irq_pend & ~model));
  endtask

  initial begin
    void'($urandom(32'd1234));
    model = '1;
    irq_pend = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 masked", irq_masked, 0); chk("R1 req", irq_req, 0);
    read_all("R1");
    wr(8'h0C, 32'h0000_0000, "R2"); read_all("R2");
    wr(8'h08, 32'hF0F0_1234, "R3"); read_all("R3");
    wr(8'h1C, 32'h40, "R4"); read_all("R4");
    wr(8'h1D, 32'h40, "R6"); read_all("R6");
    wr(8'h1C, 32'd63, "R5 bit63"); read_all("R5 bit63");
    wr(8'h1C, 32'd0, "R5 bit0"); read_all("R5 bit0");
    wr(8'h1C, 32'h40, "R4 again");
    wr(8'h1D, 32'd32, "R7 bit32"); read_all("R7 bit32");
    wr(8'h1D, 32'd31, "R7 bit31"); read_all("R7 bit31");
    wr(8'h30, 32'hFFFF_FFFF, "R10"); read_all("R10");
    wr(8'h1E, 32'h40, "R10 near"); read_all("R10 near");
    @(negedge clk); addr = 8'h1C; #1 chk("R9 set read", rdata, 0);
    addr = 8'h1D; #1 chk("R9 clr read", rdata, 0);
    irq_pend = 64'h8000_0000_0000_0001; read_all("R8 pend");
    irq_pend = 0; read_all("R8 idle");
    for (int i = 0; i < 200; i++) begin
      logic [7:0] a;
      logic [31:0] d;
      case ($urandom % 6)
        0: a = 8'h08; 1: a = 8'h0C; 2, 3: a = 8'h1C; 4: a = 8'h1D;
        default: a = 8'h1D;
      endcase
      if ($urandom % 10 == 0) a = 8'($urandom);
      d = $urandom;
      if (a[4] && $urandom % 4 != 0) d[6] = 0;
      irq_pend = {$urandom, $urandom};
      wr(a, d, "R5 R7 R8 rand");
      read_all("R2 R3 R8 rand");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule